// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block walks a string of bytes or words through memory on behalf of a processor core. It runs one of five element operations: move, load, store, scan or compare. A single start pulse hands it the opening source index, destination index, repeat count and accumulator value, along with the direction, element size, operation and repeat mode. From then on the block issues one memory access at a time over a request/ready handshake, steps the index registers and counts down repetitions. It raises a one-cycle done pulse when the string is finished.

The sequencer copies no data beyond the one element it holds between a source read and a destination write. It keeps the accumulator and the zero flag as outputs so that the surrounding core can pick up the result of a load, a scan or a compare. Scan and compare repeats can end early on the zero flag. A zero repeat count ends the operation without a single access.

Top module: `strop_seq`

## Requirements
- R1: With the direction input at 0 every index the operation uses is incremented after each element. With it at 1 each such index is decremented.
- R2: The index step is 1 when the word input is 0 (byte elements) and 2 when it is 1 (word elements). A byte element uses bits 7:0 of the data, a word element uses bits 15:0.
- R3: Operation codes are 0 move, 1 load, 2 store, 3 scan and 4 compare. Move and compare step both indexes. Load steps only the source index. Store and scan step only the destination index.
- R4: With repeat mode 1 or 2 the count drops by exactly one per element. The operation ends after the element that brings the count to zero.
- R5: With repeat mode 1 or 2 and a start count of zero, no request is issued. Done rises in the first cycle after the start edge, and the loaded index and count values remain unchanged.
- R6: With repeat mode 0 exactly one element is processed and the count output keeps the value loaded at start.
- R7: A load writes the element into the accumulator, keeping bits 15:8 when the element is a byte. A store writes the accumulator to the destination index.
- R8: A scan compares the accumulator with the element read at the destination index. A compare compares the element read at the source index with the element read at the destination index. Either one sets the zero flag when the two are equal and clears it otherwise. No other operation changes the zero flag.
- R9: For scan and compare, repeat mode 1 stops after an element that clears the zero flag, and repeat mode 2 stops after an element that sets it. In both cases that element's index and count updates are kept. For move, load and store, modes 1 and 2 both repeat until the count runs out.
- R10: Index arithmetic wraps modulo 2^16.
- R11: Each element reads the source index first when it needs one, then accesses the destination index. A request selects the destination index when req_dst is 1 and the source index when it is 0. A request is held unchanged until mem_ready is seen high with it. Read data are taken in the cycle of that handshake.
- R12: Done is a single-cycle pulse that rises together with busy falling. Busy is high from the cycle after a start with work to do until done. No request is issued while busy is low, and a start pulse is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation with the start_* values |
| start_op | input | 3 | Operation code (0 move, 1 load, 2 store, 3 scan, 4 compare) |
| start_rep | input | 2 | Repeat mode (0 none, 1 while equal, 2 while not equal) |
| start_dir | input | 1 | 0 step up, 1 step down |
| start_word | input | 1 | 0 byte elements, 1 word elements |
| start_si | input | AW | Initial source index |
| start_di | input | AW | Initial destination index |
| start_cx | input | CW | Initial repeat count |
| start_acc | input | DW | Accumulator value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| si | output | AW | Source index register |
| di | output | AW | Destination index register |
| cx | output | CW | Repeat count register |
| acc | output | DW | Accumulator |
| zf | output | 1 | Zero flag from the last scan or compare |
| req_valid | output | 1 | Memory request present |
| req_write | output | 1 | 1 write, 0 read |
| req_dst | output | 1 | 1 destination index, 0 source index |
| req_word | output | 1 | 1 word access, 0 byte access |
| req_addr | output | AW | Offset of the access |
| req_wdata | output | DW | Write data |
| mem_ready | input | 1 | Access completes in this cycle |
| mem_rdata | input | DW | Read data, valid with mem_ready |

## Verification
A start sampled at one edge makes busy, the loaded registers and the first request visible after that same edge. A zero-count repeat makes done visible after it instead. Each access ends on the edge where mem_ready is high. Each element then takes one further step cycle, and the index and count updates and the done pulse appear after that step edge. The bench drives stimulus and samples on the falling edge, and waits for done before comparing the index, count, accumulator, flag, access counts and memory image. For a zero count it checks done on the very first falling edge after the start edge. It checks that done is low again one cycle later.

// File: rtl/strop_pkg.sv
package strop_pkg;

  typedef enum logic [2:0] {
    OP_MOVE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_SCAN  = 3'd3,
    OP_CMP   = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    RP_NONE     = 2'd0,
    RP_WHILE_EQ = 2'd1,
    RP_WHILE_NE = 2'd2
  } rep_e;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SRC_RD = 3'd1,
    PH_DST_RD = 3'd2,
    PH_DST_WR = 3'd3,
    PH_STEP   = 3'd4
  } phase_e;

  function automatic logic op_reads_src(op_e o);
    return (o == OP_MOVE) || (o == OP_LOAD) || (o == OP_CMP);
  endfunction

  function automatic logic op_reads_dst(op_e o);
    return (o == OP_SCAN) || (o == OP_CMP);
  endfunction

  function automatic logic op_writes_dst(op_e o);
    return (o == OP_MOVE) || (o == OP_STORE);
  endfunction

  function automatic logic op_compares(op_e o);
    return (o == OP_SCAN) || (o == OP_CMP);
  endfunction

  function automatic phase_e phase_after_src(op_e o);
    if (op_reads_dst(o))       return PH_DST_RD;
    else if (op_writes_dst(o)) return PH_DST_WR;
    else                       return PH_STEP;
  endfunction

  function automatic phase_e phase_first(op_e o);
    if (op_reads_src(o)) return PH_SRC_RD;
    else                 return phase_after_src(o);
  endfunction

endpackage

// File: rtl/strop_index_step.sv
module strop_index_step #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cur,
  input  logic          en,
  input  logic          down,
  input  logic          word,
  output logic [AW-1:0] nxt
);
  localparam logic [AW-1:0] STEP_B = AW'(1);
  localparam logic [AW-1:0] STEP_W = AW'(2);

  logic [AW-1:0] amount;

  always_comb begin
    amount = word ? STEP_W : STEP_B;
    if (!en)       nxt = cur;
    else if (down) nxt = cur - amount;
    else           nxt = cur + amount;
  end
endmodule

// File: rtl/strop_count.sv
module strop_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] value,
  output logic          is_one
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - ONE;
  end

  assign value  = cnt_q;
  assign is_one = (cnt_q == ONE);
endmodule

// File: rtl/strop_ctrl.sv
module strop_ctrl
  import strop_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  input  op_e    start_op,
  input  rep_e   start_rep,
  input  logic   start_dir,
  input  logic   start_word,
  input  logic   start_cx_zero,
  input  logic   mem_ready,
  input  logic   cx_one,
  input  logic   zf,
  output op_e    op,
  output rep_e   rep,
  output logic   dir,
  output logic   word,
  output phase_e phase,
  output logic   load_en,
  output logic   step_en,
  output logic   cnt_dec,
  output logic   done
);
  phase_e phase_q, phase_d;
  op_e    op_q;
  rep_e   rep_q;
  logic   dir_q, word_q, done_q, fin;
  logic   stop_now, early_end;

  always_comb begin
    early_end = op_compares(op_q) &&
                (((rep_q == RP_WHILE_EQ) && !zf) ||
                 ((rep_q == RP_WHILE_NE) &&  zf));
    stop_now  = (rep_q == RP_NONE) || cx_one || early_end;
  end

  always_comb begin
    phase_d = phase_q;
    fin     = 1'b0;
    load_en = 1'b0;
    step_en = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          load_en = 1'b1;
          if ((start_rep != RP_NONE) && start_cx_zero) fin = 1'b1;
          else phase_d = phase_first(start_op);
        end
      end
      PH_SRC_RD: if (mem_ready) phase_d = phase_after_src(op_q);
      PH_DST_RD: if (mem_ready) phase_d = PH_STEP;
      PH_DST_WR: if (mem_ready) phase_d = PH_STEP;
      PH_STEP: begin
        step_en = 1'b1;
        if (stop_now) begin
          fin     = 1'b1;
          phase_d = PH_IDLE;
        end else begin
          phase_d = phase_first(op_q);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
      op_q    <= OP_MOVE;
      rep_q   <= RP_NONE;
      dir_q   <= 1'b0;
      word_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= fin;
      if (load_en) begin
        op_q   <= start_op;
        rep_q  <= start_rep;
        dir_q  <= start_dir;
        word_q <= start_word;
      end
    end
  end

  assign cnt_dec = step_en && (rep_q != RP_NONE);
  assign op      = op_q;
  assign rep     = rep_q;
  assign dir     = dir_q;
  assign word    = word_q;
  assign phase   = phase_q;
  assign done    = done_q;
endmodule

// File: rtl/strop_seq.sv
module strop_seq
  import strop_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    start_op,
  input  logic [1:0]    start_rep,
  input  logic          start_dir,
  input  logic          start_word,
  input  logic [AW-1:0] start_si,
  input  logic [AW-1:0] start_di,
  input  logic [CW-1:0] start_cx,
  input  logic [DW-1:0] start_acc,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] si,
  output logic [AW-1:0] di,
  output logic [CW-1:0] cx,
  output logic [DW-1:0] acc,
  output logic          zf,
  output logic          req_valid,
  output logic          req_write,
  output logic          req_dst,
  output logic          req_word,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata
);
  localparam int BW = DW / 2;

  op_e    op_q;
  rep_e   rep_q;
  phase_e phase;
  logic   dir_q, word_q, load_en, step_en, cnt_dec, cx_one;
  logic   hs;
  logic [DW-1:0] tmp_q, acc_q, cmp_a;
  logic          zf_q, eq;

  strop_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .start_op     (op_e'(start_op)),
    .start_rep    (rep_e'(start_rep)),
    .start_dir    (start_dir),
    .start_word   (start_word),
    .start_cx_zero(start_cx == '0),
    .mem_ready    (mem_ready),
    .cx_one       (cx_one),
    .zf           (zf_q),
    .op           (op_q),
    .rep          (rep_q),
    .dir          (dir_q),
    .word         (word_q),
    .phase        (phase),
    .load_en      (load_en),
    .step_en      (step_en),
    .cnt_dec      (cnt_dec),
    .done         (done)
  );

  strop_count #(.CW(CW)) u_count (
    .clk     (clk),
    .rst     (rst),
    .load    (load_en),
    .load_val(start_cx),
    .dec     (cnt_dec),
    .value   (cx),
    .is_one  (cx_one)
  );

  for (genvar g = 0; g < 2; g++) begin : g_idx
    logic [AW-1:0] cur_q, nxt, init;
    logic          used;

    assign init = (g == 0) ? start_si : start_di;
    assign used = (g == 0) ? op_reads_src(op_q)
                           : (op_reads_dst(op_q) || op_writes_dst(op_q));

    strop_index_step #(.AW(AW)) u_step (
      .cur (cur_q),
      .en  (step_en && used),
      .down(dir_q),
      .word(word_q),
      .nxt (nxt)
    );

    always_ff @(posedge clk) begin
      if (rst)          cur_q <= '0;
      else if (load_en) cur_q <= init;
      else              cur_q <= nxt;
    end
  end

  assign si = g_idx[0].cur_q;
  assign di = g_idx[1].cur_q;

  assign hs    = req_valid && mem_ready;
  assign cmp_a = (op_q == OP_SCAN) ? acc_q : tmp_q;
  assign eq    = word_q ? (cmp_a == mem_rdata)
                        : (cmp_a[BW-1:0] == mem_rdata[BW-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      tmp_q <= '0;
      zf_q  <= 1'b0;
    end else if (load_en) begin
      acc_q <= start_acc;
    end else if (hs) begin
      if (phase == PH_SRC_RD) begin
        if (op_q == OP_LOAD) begin
          if (word_q) acc_q <= mem_rdata;
          else        acc_q[BW-1:0] <= mem_rdata[BW-1:0];
        end else begin
          tmp_q <= mem_rdata;
        end
      end else if (phase == PH_DST_RD) begin
        zf_q <= eq;
      end
    end
  end

  assign busy      = (phase != PH_IDLE);
  assign req_valid = (phase == PH_SRC_RD) || (phase == PH_DST_RD) ||
                     (phase == PH_DST_WR);
  assign req_write = (phase == PH_DST_WR);
  assign req_dst   = (phase == PH_DST_RD) || (phase == PH_DST_WR);
  assign req_word  = word_q;
  assign req_addr  = req_dst ? di : si;
  assign req_wdata = (op_q == OP_STORE) ? acc_q : tmp_q;
  assign acc       = acc_q;
  assign zf        = zf_q;
endmodule

// File: rtl/strop_seq_chk.sv
module strop_seq_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [1:0]    start_rep,
  input logic [CW-1:0] start_cx,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] si,
  input logic [AW-1:0] di,
  input logic [CW-1:0] cx,
  input logic          req_valid,
  input logic          req_write,
  input logic          req_dst,
  input logic [AW-1:0] req_addr,
  input logic          mem_ready
);
  function automatic logic small_step(logic [AW-1:0] d);
    return (d == '0) || (d == AW'(1)) || (d == AW'(2)) ||
           (d == {AW{1'b1}}) || (d == ({AW{1'b1}} - AW'(1)));
  endfunction

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
    req_valid && !mem_ready |=> req_valid && $stable(req_addr) &&
                                $stable(req_write) && $stable(req_dst));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> !done);

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !req_valid);

  assert_cx_step_R4: assert property (@(posedge clk) disable iff (rst)
    busy |=> (cx == $past(cx)) || (cx == ($past(cx) - CW'(1))));

  assert_si_step_R2: assert property (@(posedge clk) disable iff (rst)
    busy |=> small_step(si - $past(si)));

  assert_di_step_R2: assert property (@(posedge clk) disable iff (rst)
    busy |=> small_step(di - $past(di)));

  assert_zero_cnt_R5: assert property (@(posedge clk) disable iff (rst)
    start && !busy && (start_rep != 2'd0) && (start_cx == '0)
    |=> done && !busy);
endmodule

bind strop_seq strop_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .start_rep(start_rep),
  .start_cx (start_cx),
  .busy     (busy),
  .done     (done),
  .si       (si),
  .di       (di),
  .cx       (cx),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_dst  (req_dst),
  .req_addr (req_addr),
  .mem_ready(mem_ready)
);

// File: tb/tb_strop_seq.sv
module tb_strop_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  start_op = '0;
  logic [1:0]  start_rep = '0;
  logic        start_dir = 1'b0, start_word = 1'b0;
  logic [15:0] start_si = '0, start_di = '0, start_cx = '0, start_acc = '0;
  logic        busy, done, zf, req_valid, req_write, req_dst, req_word;
  logic [15:0] si, di, cx, acc, req_addr, req_wdata;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_rdata = '0;

  strop_seq dut (.*);

  always #10 clk = ~clk;

  logic [7:0] mem  [0:255];
  logic [7:0] rmem [0:255];
  int ws = 0, wcnt = 0, n_rd = 0, n_wr = 0;
  int vectors = 0, errors = 0;
  int e_rd, e_wr;
  logic [15:0] e_si, e_di, e_cx, e_acc;
  logic        e_zf = 1'b0;

  always @(negedge clk) begin
    if (rst || !req_valid) begin
      mem_ready = 1'b0;
      wcnt = 0;
    end else if (wcnt >= ws) begin
      logic [7:0] a0, a1;
      a0 = req_addr[7:0];
      a1 = a0 + 8'd1;
      mem_ready = 1'b1;
      wcnt = 0;
      if (req_write) begin
        n_wr++;
        mem[a0] = req_wdata[7:0];
        if (req_word) mem[a1] = req_wdata[15:8];
      end else begin
        n_rd++;
        mem_rdata = {mem[a1], mem[a0]};
      end
    end else begin
      mem_ready = 1'b0;
      wcnt++;
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [15:0] ref_rd(input logic [15:0] a);
    logic [7:0] a0, a1;
    a0 = a[7:0];
    a1 = a0 + 8'd1;
    e_rd++;
    return {rmem[a1], rmem[a0]};
  endfunction

  task automatic ref_wr(input logic [15:0] a, input logic [15:0] v, input logic wd);
    logic [7:0] a0, a1;
    a0 = a[7:0];
    a1 = a0 + 8'd1;
    e_wr++;
    rmem[a0] = v[7:0];
    if (wd) rmem[a1] = v[15:8];
  endtask

  task automatic ref_model(input int op, input int rep, input logic dir, input logic wd);
    logic [15:0] st, v, w;
    logic go;
    for (int i = 0; i < 256; i++) rmem[i] = mem[i];
    e_rd = 0; e_wr = 0;
    e_si = start_si; e_di = start_di; e_cx = start_cx; e_acc = start_acc;
    st = wd ? 16'd2 : 16'd1;
    go = !(rep != 0 && e_cx == 0);
    while (go) begin
      case (op)
        0: begin v = ref_rd(e_si); ref_wr(e_di, v, wd); end
        1: begin v = ref_rd(e_si); e_acc = wd ? v : {e_acc[15:8], v[7:0]}; end
        2: ref_wr(e_di, e_acc, wd);
        3: begin v = ref_rd(e_di); e_zf = wd ? (e_acc == v) : (e_acc[7:0] == v[7:0]); end
        default: begin
          v = ref_rd(e_si); w = ref_rd(e_di);
          e_zf = wd ? (v == w) : (v[7:0] == w[7:0]);
        end
      endcase
      if (op == 0 || op == 1 || op == 4) e_si = dir ? e_si - st : e_si + st;
      if (op != 1) e_di = dir ? e_di - st : e_di + st;
      if (rep == 0) go = 1'b0;
      else begin
        e_cx = e_cx - 16'd1;
        if (e_cx == 0) go = 1'b0;
        else if (op >= 3 && ((rep == 1 && !e_zf) || (rep == 2 && e_zf))) go = 1'b0;
      end
    end
  endtask

  // Runs one operation and compares every result with the reference.
  task automatic run(input int op, input int rep, input logic dir, input logic wd,
                     input logic [15:0] s0, input logic [15:0] d0, input logic [15:0] c0,
                     input logic [15:0] a0, input string req);
    int cyc, bad;
    @(negedge clk);
    start_op = 3'(op); start_rep = 2'(rep); start_dir = dir; start_word = wd;
    start_si = s0; start_di = d0; start_cx = c0; start_acc = a0;
    ref_model(op, rep, dir, wd);
    n_rd = 0; n_wr = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R12", "done seen", int'(done), 1);
    if (rep != 0 && c0 == 0) chk("R5", "zero-count done cycle", cyc, 1);
    chk(req, "si", si, e_si);
    chk(req, "di", di, e_di);
    chk(req, "cx", cx, e_cx);
    chk(req, "acc", acc, e_acc);
    chk(req, "zf", int'(zf), int'(e_zf));
    chk(req, "reads", n_rd, e_rd);
    chk(req, "writes", n_wr, e_wr);
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== rmem[i]) bad++;
    chk(req, "memory bytes differing", bad, 0);
    @(negedge clk);
    chk("R12", "done width", int'(done), 0);
    chk("R12", "busy after done", int'(busy), 0);
  endtask

  task automatic t_reset;
    chk("R12", "reset busy", int'(busy), 0);
    chk("R12", "reset done", int'(done), 0);
    chk("R12", "reset req_valid", int'(req_valid), 0);
    chk("R4", "reset cx", cx, 0);
  endtask

  task automatic t_move_up_byte;     // R1 R2 R3 R4
    ws = 0;
    run(0, 1, 1'b0, 1'b0, 16'h0010, 16'h0040, 16'd5, 16'h0, "R1 R2 R3 R4");
  endtask

  task automatic t_move_down_word;   // R1 R2 R11 with wait states
    ws = 2;
    run(0, 2, 1'b1, 1'b1, 16'h002E, 16'h008E, 16'd4, 16'h0, "R1 R2 R11");
    ws = 0;
  endtask

  task automatic t_load_single;      // R6 R7: AH kept, cx unchanged
    run(1, 0, 1'b0, 1'b0, 16'h0020, 16'h0099, 16'd7, 16'hAB00, "R6 R7 R3");
  endtask

  task automatic t_store_rep;        // R7 R3 R4
    run(2, 1, 1'b0, 1'b1, 16'h0055, 16'h0060, 16'd3, 16'h1234, "R7 R3 R4");
  endtask

  task automatic t_scan_until_match; // R8 R9
    mem[8'h70] = 8'h11; mem[8'h71] = 8'h22; mem[8'h72] = 8'h55; mem[8'h73] = 8'h55;
    run(3, 2, 1'b0, 1'b0, 16'h0001, 16'h0070, 16'd8, 16'h0055, "R8 R9");
    chk("R9", "scan stop index", di, 16'h0073);
    chk("R9", "scan stop count", cx, 5);
  endtask

  task automatic t_cmp_until_diff;   // R8 R9
    mem[8'h80] = 8'h34; mem[8'h81] = 8'h12; mem[8'hA0] = 8'h34; mem[8'hA1] = 8'h12;
    mem[8'h82] = 8'h00; mem[8'h83] = 8'h77; mem[8'hA2] = 8'h01; mem[8'hA3] = 8'h77;
    run(4, 1, 1'b0, 1'b1, 16'h0080, 16'h00A0, 16'd6, 16'h0, "R8 R9");
    chk("R9", "compare stop zf", int'(zf), 0);
    chk("R9", "compare stop count", cx, 4);
  endtask

  task automatic t_zero_count;       // R5
    run(0, 1, 1'b0, 1'b1, 16'h0030, 16'h0050, 16'd0, 16'h0, "R5");
    chk("R5", "zero-count si", si, 16'h0030);
  endtask

  task automatic t_wrap;             // R10
    run(0, 1, 1'b0, 1'b1, 16'hFFFF, 16'hFFFE, 16'd2, 16'h0, "R10");
    chk("R10", "si wrapped", si, 16'h0003);
    run(2, 2, 1'b1, 1'b0, 16'h0000, 16'h0001, 16'd3, 16'h00E7, "R10");
    chk("R10", "di wrapped", di, 16'hFFFE);
  endtask

  task automatic t_scan_all_equal;   // R4 R9
    for (int i = 8'hC0; i < 8'hC4; i++) mem[i] = 8'h3C;
    run(3, 1, 1'b0, 1'b0, 16'h0000, 16'h00C0, 16'd4, 16'h773C, "R4 R9");
    chk("R4", "count exhausted", cx, 0);
  endtask

  task automatic t_cmp_single;       // R6 R8
    run(4, 0, 1'b1, 1'b0, 16'h0090, 16'h00B0, 16'd9, 16'h0, "R6 R8");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 13 + 5);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_move_up_byte();
    t_move_down_word();
    t_load_single();
    t_store_rep();
    t_scan_until_match();
    t_cmp_until_diff();
    t_zero_count();
    t_wrap();
    t_scan_all_equal();
    t_cmp_single();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule